// File: doc/BRIEF.md
# ADC Capture Core Reset and Lane Control Registers

This block is the top-level control register bank of an ADC capture core. Software reaches it through a simple 32-bit memory-mapped port with word addressing, a 4-byte stride and a read response one cycle after the request. It drives the reset and clock-enable controls, the active lane count, the sampling-edge select, an interface-alignment request and one 5-bit input-delay tap per lane into the capture datapath.

Bring-up is done in steps. Software first releases the clock-generator reset. It then polls the lock status until the clock generator reports lock, and only then releases the core reset. The hardware adds a gate of its own: the core reset output is released only while the synchronized lock input is high. Software starts an alignment with a request bit and polls a sticky completion flag. The flag is cleared by writing the request back to zero. A delay-tap read returns all ones while the delay clock is reported absent, which lets software detect a dead delay clock.

The lock, alignment-done and delay-clock-present inputs each pass through a two-flop synchronizer before use. Register access works at all times, including while every reset control holds the core in reset.

Top module: `adc_ctrl_regs`

## Requirements
- R1: After reset, `core_rst_n`, `clkgen_rst_n` and `clk_en_n` are 0, `lane_count` is 1, `edge_fall` and `align_req` are 0, and every lane tap is 0.
- R2: The reset register at byte offset 0x40 stores write-data bits 2:0 and reads back with all other bits 0. Bit 1 drives `clkgen_rst_n` and bit 2 drives `clk_en_n`, both from the clock edge that takes the write. Writing 0 drives all three reset outputs low while register access keeps working.
- R3: `core_rst_n` is 1 only when reset-register bits 0 and 1 are both 1 and the synchronized lock input is 1. It updates on the edge after the inputs to that decision change.
- R4: Bit 17 of the lock status register at offset 0x74 reads the lock input after two-flop synchronization. All other bits of that register read 0.
- R5: In the control register at offset 0x44, bits 12:8 set `lane_count` and bit 1 sets `edge_fall` (1 = falling edge, 0 = rising edge). A write whose lane field is 0 leaves the lane count unchanged but still updates the other fields.
- R6: Bit 3 of the control register drives `align_req`. Bit 0 of the sync status register at offset 0x68 becomes 1 once the synchronized alignment-done input is seen high while the request is 1. It stays 1 after alignment-done falls. It clears when the request is written to 0. Alignment-done seen while the request is 0 does not set it.
- R7: The tap register of lane l sits at offset 0x800 + 4*l, for l below `N_LANES`. It stores write-data bits 4:0, drives `lane_taps[5*l+4:5*l]` and reads back zero-extended. Upper write-data bits are ignored.
- R8: While the synchronized delay-clock-present input is 0, every tap register reads 0xFFFFFFFF. The stored taps and their outputs are kept, and they read back normally once the input returns to 1.
- R9: Bit 7 of the configuration register at offset 0x0C reads `iface_cmos` (1 = CMOS, 0 = LVDS). All other bits read 0.
- R10: Reads of unmapped or misaligned addresses return 0. Writes to them change no register, and a tap offset at or beyond `N_LANES` counts as unmapped.
- R11: `rsp_valid` is 1 in exactly the cycle after a read request is accepted, with `rsp_rdata` valid in that cycle. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| lock_in | input | 1 | Clock-generator lock, asynchronous |
| align_done_in | input | 1 | Interface alignment complete, asynchronous |
| delay_clk_ok | input | 1 | Delay clock domain running, asynchronous |
| iface_cmos | input | 1 | Interface type strap, 1 = CMOS |
| core_rst_n | output | 1 | Active-low core reset to the datapath |
| clkgen_rst_n | output | 1 | Active-low clock-generator reset |
| clk_en_n | output | 1 | Active-low clock enable |
| lane_count | output | 5 | Active lane count, never 0 |
| edge_fall | output | 1 | Sample on the falling edge when 1 |
| align_req | output | 1 | Interface alignment request |
| lane_taps | output | N_LANES*5 | Per-lane delay taps, lane 0 in the low bits |

## Verification
The assertions assume that the three status inputs are asynchronous levels that stay put long enough to be synchronized. They also assume that `iface_cmos` is a static strap and that at most one access is presented per cycle. The stimulus changes a status input only at a falling clock edge and then waits several cycles before it reads the effect. It holds `iface_cmos` steady while reading it, and each access lasts exactly one cycle. Under these conditions the sweeps cover every reset-register value against both lock states, every lane count including 0, every tap value and every lane.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;

    localparam int REG_W  = 32;
    localparam int TAP_W  = 5;
    localparam int LANE_W = 5;

    // word offsets (byte offset / 4)
    localparam int OFF_CFG  = 3;    // 0x00C
    localparam int OFF_RST  = 16;   // 0x040
    localparam int OFF_CTRL = 17;   // 0x044
    localparam int OFF_SYNC = 26;   // 0x068
    localparam int OFF_LOCK = 29;   // 0x074
    localparam int OFF_TAP  = 512;  // 0x800

    localparam int BIT_CORE   = 0;
    localparam int BIT_CLKGEN = 1;
    localparam int BIT_CLKEN  = 2;
    localparam int BIT_EDGE   = 1;
    localparam int BIT_ALIGN  = 3;
    localparam int LANE_LSB   = 8;
    localparam int BIT_LOCK   = 17;
    localparam int BIT_IFTYPE = 7;

    typedef struct packed {
        logic [2:0]        rst;
        logic              core;
        logic [LANE_W-1:0] lanes;
        logic              edge_f;
        logic              align;
        logic              flag;
        logic              rvalid;
        logic [REG_W-1:0]  rdata;
    } ctrl_state_t;

endpackage

// File: rtl/adc_sync2.sv
module adc_sync2 #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [1:0] stage_d, stage_q;
            always_comb stage_d = {stage_q[0], async_in[i]};
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q <= '0;
                else        stage_q <= stage_d;
            end
            assign sync_out[i] = stage_q[1];
        end
    endgenerate
endmodule

// File: rtl/adc_tap_bank.sv
module adc_tap_bank
    import adc_ctrl_pkg::*;
#(
    parameter int N_LANES = 16,
    localparam int LIDX_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [LIDX_W-1:0]        wr_lane,
    input  logic [TAP_W-1:0]         wr_tap,
    input  logic [LIDX_W-1:0]        rd_lane,
    output logic [TAP_W-1:0]         rd_tap,
    output logic [N_LANES*TAP_W-1:0] taps_flat
);
    logic [TAP_W-1:0] taps_d [N_LANES];
    logic [TAP_W-1:0] taps_q [N_LANES];

    always_comb begin
        for (int l = 0; l < N_LANES; l++) begin
            taps_d[l] = taps_q[l];
            if (wr_en && (int'(wr_lane) == l)) taps_d[l] = wr_tap;
        end
        rd_tap = '0;
        for (int l = 0; l < N_LANES; l++) begin
            if (int'(rd_lane) == l) rd_tap = taps_q[l];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int l = 0; l < N_LANES; l++) taps_q[l] <= '0;
        end else begin
            for (int l = 0; l < N_LANES; l++) taps_q[l] <= taps_d[l];
        end
    end

    genvar g;
    generate
        for (g = 0; g < N_LANES; g++) begin : g_lane
            assign taps_flat[g*TAP_W +: TAP_W] = taps_q[g];

            // R7: a write hitting this lane lands on its output next cycle
            assert_tap_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && int'(wr_lane) == g) |=> (taps_flat[g*TAP_W +: TAP_W] == $past(wr_tap)));
        end
    endgenerate
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
    import adc_ctrl_pkg::*;
#(
    parameter int N_LANES = 16,
    parameter int ADDR_W  = 12,
    localparam int WORD_W = ADDR_W - 2,
    localparam int LIDX_W = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [REG_W-1:0]         req_wdata,
    output logic                     rsp_valid,
    output logic [REG_W-1:0]         rsp_rdata,
    input  logic                     lock_in,
    input  logic                     align_done_in,
    input  logic                     delay_clk_ok,
    input  logic                     iface_cmos,
    output logic                     core_rst_n,
    output logic                     clkgen_rst_n,
    output logic                     clk_en_n,
    output logic [LANE_W-1:0]        lane_count,
    output logic                     edge_fall,
    output logic                     align_req,
    output logic [N_LANES*TAP_W-1:0] lane_taps
);
    ctrl_state_t st_d, st_q;

    logic [2:0] stat_s;
    logic lock_s, done_s, dclk_s;

    adc_sync2 #(.WIDTH(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({delay_clk_ok, align_done_in, lock_in}),
        .sync_out (stat_s)
    );
    assign lock_s = stat_s[0];
    assign done_s = stat_s[1];
    assign dclk_s = stat_s[2];

    // address decode
    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] lane_off;
    logic              aligned, tap_hit, wr, rd;
    logic [LIDX_W-1:0] lane_idx;
    logic [TAP_W-1:0]  rd_tap;

    assign word     = req_addr[ADDR_W-1:2];
    assign aligned  = (req_addr[1:0] == 2'b00);
    assign lane_off = word - WORD_W'(OFF_TAP);
    assign tap_hit  = aligned && (word >= WORD_W'(OFF_TAP)) && (lane_off < WORD_W'(N_LANES));
    assign lane_idx = lane_off[LIDX_W-1:0];
    assign wr       = req_valid && req_write;
    assign rd       = req_valid && !req_write;

    adc_tap_bank #(.N_LANES(N_LANES)) u_taps (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr && tap_hit),
        .wr_lane   (lane_idx),
        .wr_tap    (req_wdata[TAP_W-1:0]),
        .rd_lane   (lane_idx),
        .rd_tap    (rd_tap),
        .taps_flat (lane_taps)
    );

    logic [REG_W-1:0] rd_mux;

    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            case (word)
                WORD_W'(OFF_CFG):  rd_mux[BIT_IFTYPE] = iface_cmos;
                WORD_W'(OFF_RST):  rd_mux[2:0] = st_q.rst;
                WORD_W'(OFF_CTRL): begin
                    rd_mux[LANE_LSB +: LANE_W] = st_q.lanes;
                    rd_mux[BIT_ALIGN]          = st_q.align;
                    rd_mux[BIT_EDGE]           = st_q.edge_f;
                end
                WORD_W'(OFF_SYNC): rd_mux[0] = st_q.flag;
                WORD_W'(OFF_LOCK): rd_mux[BIT_LOCK] = lock_s;
                default: begin
                    if (tap_hit) rd_mux = dclk_s ? {{(REG_W-TAP_W){1'b0}}, rd_tap} : '1;
                end
            endcase
        end
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd;
        if (rd) st_d.rdata = rd_mux;

        if (wr && aligned && word == WORD_W'(OFF_RST)) st_d.rst = req_wdata[2:0];
        if (wr && aligned && word == WORD_W'(OFF_CTRL)) begin
            if (req_wdata[LANE_LSB +: LANE_W] != '0) st_d.lanes = req_wdata[LANE_LSB +: LANE_W];
            st_d.edge_f = req_wdata[BIT_EDGE];
            st_d.align  = req_wdata[BIT_ALIGN];
        end

        st_d.flag = st_d.align ? (st_q.flag || (st_q.align && done_s)) : 1'b0;
        st_d.core = st_d.rst[BIT_CORE] && st_d.rst[BIT_CLKGEN] && lock_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.lanes <= LANE_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid    = st_q.rvalid;
    assign rsp_rdata    = st_q.rdata;
    assign core_rst_n   = st_q.core;
    assign clkgen_rst_n = st_q.rst[BIT_CLKGEN];
    assign clk_en_n     = st_q.rst[BIT_CLKEN];
    assign lane_count   = st_q.lanes;
    assign edge_fall    = st_q.edge_f;
    assign align_req    = st_q.align;

    logic unused_bits;
    assign unused_bits = ^{req_wdata[REG_W-1:LANE_LSB+LANE_W], req_wdata[LANE_LSB-1:BIT_ALIGN+1],
                           req_wdata[0], lane_off};

    // R3: core released only with lock seen and clock generator released
    assert_core_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_n |-> ($past(lock_s) && clkgen_rst_n));

    // R5: lane count can never become zero
    assert_lanes_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        lane_count != '0);

    // R6: completion flag only exists under a live request
    assert_flag_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.flag |-> align_req);

    // R11: response exactly one cycle after a read
    assert_rsp_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write));

    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);
endmodule

// File: tb/adc_ctrl_regs_bench.sv
module adc_ctrl_regs_bench;
    localparam int CLK_P   = 10;
    localparam int N_LANES = 16;
    localparam int ADDR_W  = 12;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic lock_in = 0, align_done_in = 0, delay_clk_ok = 1, iface_cmos = 0;
    logic core_rst_n, clkgen_rst_n, clk_en_n, edge_fall, align_req;
    logic [4:0] lane_count;
    logic [N_LANES*5-1:0] lane_taps;

    int n_tests = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_ctrl_regs #(.N_LANES(N_LANES), .ADDR_W(ADDR_W)) u_adc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .lock_in(lock_in), .align_done_in(align_done_in),
        .delay_clk_ok(delay_clk_ok), .iface_cmos(iface_cmos), .core_rst_n(core_rst_n),
        .clkgen_rst_n(clkgen_rst_n), .clk_en_n(clk_en_n), .lane_count(lane_count),
        .edge_fall(edge_fall), .align_req(align_req), .lane_taps(lane_taps)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        d = rsp_rdata;
        check("R11 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [4:0] last_lanes;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 core_rst_n", {31'b0, core_rst_n}, 0);
        check("R1 clkgen_rst_n", {31'b0, clkgen_rst_n}, 0);
        check("R1 clk_en_n", {31'b0, clk_en_n}, 0);
        check("R1 lane_count", {27'b0, lane_count}, 1);
        check("R1 edge/align", {30'b0, edge_fall, align_req}, 0);
        check("R1 taps", {31'b0, lane_taps == '0}, 1);
        check("R11 idle no rsp", {31'b0, rsp_valid}, 0);

        // R2/R3/R4 sweep reset register against lock
        for (int lk = 0; lk < 2; lk++) begin
            lock_in = lk[0];
            settle();
            rd(12'h074, v);
            check("R4 lock status", v, lk[0] ? 32'h0002_0000 : 32'h0);
            for (int b = 0; b < 8; b++) begin
                wr(12'h040, 32'hFFFF_FFF8 | b);
                check("R2 clkgen_rst_n", {31'b0, clkgen_rst_n}, (b >> 1) & 1);
                check("R2 clk_en_n", {31'b0, clk_en_n}, (b >> 2) & 1);
                check("R3 core_rst_n", {31'b0, core_rst_n}, ((b & 3) == 3 && lk == 1) ? 1 : 0);
                rd(12'h040, v);
                check("R2 readback", v, b);
            end
        end
        // R3 lock loss drops core reset
        wr(12'h040, 3);
        check("R3 released", {31'b0, core_rst_n}, 1);
        lock_in = 0;
        settle();
        check("R3 lock lost", {31'b0, core_rst_n}, 0);
        // R2 write 0: all in reset, access still works
        wr(12'h040, 0);
        check("R2 all reset", {29'b0, core_rst_n, clkgen_rst_n, clk_en_n}, 0);
        wr(12'h044, 32'h0000_0300);
        rd(12'h044, v);
        check("R2 access in reset", v, 32'h0000_0300);

        // R5 lane count sweep including zero
        last_lanes = 3;
        for (int n = 0; n < 32; n++) begin
            wr(12'h044, (n << 8) | ((n & 1) << 1));
            if (n != 0) last_lanes = n[4:0];
            check("R5 lane_count", {27'b0, lane_count}, last_lanes);
            check("R5 edge_fall", {31'b0, edge_fall}, n & 1);
            rd(12'h044, v);
            check("R5 ctrl readback", v, (last_lanes << 8) | ((n & 1) << 1));
        end
        wr(12'h044, 32'h0000_0002);
        check("R5 zero lanes kept", {27'b0, lane_count}, last_lanes);
        check("R5 edge set", {31'b0, edge_fall}, 1);

        // R6 alignment
        wr(12'h044, 32'h0000_0408);
        check("R6 align_req", {31'b0, align_req}, 1);
        rd(12'h068, v);
        check("R6 not done", v, 0);
        align_done_in = 1; settle();
        rd(12'h068, v);
        check("R6 done", v, 1);
        align_done_in = 0; settle();
        rd(12'h068, v);
        check("R6 sticky", v, 1);
        wr(12'h044, 32'h0000_0400);
        rd(12'h068, v);
        check("R6 cleared", v, 0);
        align_done_in = 1; settle();
        rd(12'h068, v);
        check("R6 ignored without req", v, 0);
        wr(12'h044, 32'h0000_0408);
        settle();
        rd(12'h068, v);
        check("R6 re-request", v, 1);
        wr(12'h044, 32'h0000_0400);
        align_done_in = 0;

        // R7 all values on lane 0, then every lane
        for (int t = 0; t < 32; t++) begin
            wr(12'h800, 32'hABCD_EF00 | t);
            check("R7 lane0 out", {27'b0, lane_taps[4:0]}, t);
            rd(12'h800, v);
            check("R7 lane0 read", v, t);
        end
        for (int l = 0; l < N_LANES; l++)
            wr(12'h800 + 4*l, 32'hFFFF_FFE0 | ((l*7 + 3) & 31));
        for (int l = 0; l < N_LANES; l++) begin
            check("R7 lane out", {27'b0, lane_taps[l*5 +: 5]}, (l*7 + 3) & 31);
            rd(12'h800 + 4*l, v);
            check("R7 lane read", v, (l*7 + 3) & 31);
        end

        // R8 delay clock absent
        delay_clk_ok = 0; settle();
        for (int l = 0; l < N_LANES; l++) begin
            rd(12'h800 + 4*l, v);
            check("R8 dead clock read", v, 32'hFFFF_FFFF);
        end
        check("R8 taps kept", {27'b0, lane_taps[9:5]}, 10);
        delay_clk_ok = 1; settle();
        rd(12'h804, v);
        check("R8 recovered", v, 10);

        // R9 interface type
        iface_cmos = 1; @(negedge clk);
        rd(12'h00C, v);
        check("R9 cmos", v, 32'h80);
        iface_cmos = 0; @(negedge clk);
        rd(12'h00C, v);
        check("R9 lvds", v, 0);

        // R10 unmapped and misaligned
        wr(12'h048, 32'hFFFF_FFFF);
        wr(12'h045, 32'h0000_1F0A);
        rd(12'h044, v);
        check("R10 ctrl untouched", v, 32'h0000_0400);
        rd(12'h048, v);
        check("R10 unmapped read", v, 0);
        wr(12'h840, 32'h1F);
        wr(12'h801, 32'h1F);
        rd(12'h840, v);
        check("R10 beyond lanes read", v, 0);
        rd(12'h800, v);
        check("R10 lane0 untouched", v, 3);
        check("R10 lane0 out", {27'b0, lane_taps[4:0]}, 3);

        // R11 write produces no response
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 12'h048; req_wdata = 0;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        check("R11 no rsp on write", {31'b0, rsp_valid}, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule